// File: doc/BRIEF.md
# Thread-Interleaved Fetch Scheduler

This block decides, every clock cycle, which hardware thread sends an instruction into a five-stage pipeline. The stages are fetch, decode, execute, memory and writeback. Threads take turns in a fixed rotating order. A thread never gets a second turn while its earlier instruction is still in the pipeline, so the pipeline needs no forwarding, no interlocks and no branch prediction. The block holds one program counter per thread. It presents the thread id, that thread's PC and a valid flag to the instruction fetch stage.

The rotation has as many slots as there are threads, but never fewer than the pipeline depth. When there are fewer threads than stages, the extra slots are padding bubbles. A thread whose enable bit is low still uses its slot, as a bubble, so the other threads' issue cycles do not depend on the enable mask. Writeback returns each thread's next PC. A later stage may instead ask for the instruction to be replayed, for example a deadline wait that has not expired. A replay keeps the old PC, so the same instruction is fetched again on that thread's next turn.

Top module: `thread_fetch_sched`

## Requirements
- R1: While reset is held, and for the two synchronizer cycles after it is released, `fet_tid` is 0 and every thread PC equals the boot address (0x00000000 by default).
- R2: Out of reset, `fet_tid` goes up by one every cycle and wraps from RING-1 to 0. RING is the larger of the thread count and the stage count.
- R3: A thread id never appears twice within any window of NUM_STG consecutive fetch slots.
- R4: `fet_vld` is 1 only when `fet_tid` < NUM_THR and bit `fet_tid` of `thr_en` is 1. In every other slot it is 0.
- R5: A disabled thread still uses its slot, so the slot sequence does not change with `thr_en`.
- R6: A padding slot (`fet_tid` >= NUM_THR) has `fet_vld` = 0 and `fet_pc` = 0.
- R7: When `wb_vld` is 1 and `wb_tid` names a thread, that thread's PC takes `wb_pc` at the next clock edge. It is seen on `fet_pc` at that thread's next slot.
- R8: If `rply_vld` is 1 and `rply_tid` equals `wb_tid` in the same cycle, the writeback is dropped and the PC keeps its old value.
- R9: A replay for one thread does not block a writeback to a different thread in the same cycle.
- R10: A writeback whose `wb_tid` is NUM_THR or more changes no PC.
- R11: With no writeback aimed at it, a thread's PC holds its value. `fet_pc` shows that PC in the thread's slot whether the thread is enabled or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| thr_en | input | NUM_THR | Per-thread enable mask |
| rply_vld | input | 1 | Replay request valid |
| rply_tid | input | TID_W | Thread whose instruction is replayed |
| wb_vld | input | 1 | Next-PC update valid |
| wb_tid | input | TID_W | Thread the update is for |
| wb_pc | input | PC_W | Next PC value |
| fet_vld | output | 1 | 1 = issue in this slot, 0 = bubble |
| fet_tid | output | TID_W | Slot / thread id for this cycle |
| fet_pc | output | PC_W | PC of the thread in this slot |

## Verification
The bench builds two copies of the block. The default copy has six threads and five stages, so RING is six and there is no padding. The second copy has three threads and five stages, so RING is five and slots 3 and 4 are padding. The bench sweeps all 64 enable masks on the six-thread copy, and the low three bits of each mask on the other copy. Writeback and replay traffic comes from a shift register, and the replay id often copies the writeback id. This drives both the collision case and replays aimed at a different thread. Thread ids of 6 and 7 reach the out-of-range case on both copies.

// File: rtl/fsched_pkg.sv
package fsched_pkg;

  // Rotation length: one slot per thread, padded up to the pipeline depth.
  function automatic int ring_len(input int nthr, input int nstg);
    return (nthr >= nstg) ? nthr : nstg;
  endfunction

  typedef enum logic [1:0] {
    SLOT_ISSUE = 2'd0,
    SLOT_OFF   = 2'd1,
    SLOT_PAD   = 2'd2
  } slot_kind_e;

endpackage

// File: rtl/fsched_rst_sync.sv
module fsched_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/fsched_slot_ctr.sv
module fsched_slot_ctr #(
  parameter int RING  = 6,
  parameter int TID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TID_W-1:0] slot_o
);
  localparam logic [TID_W-1:0] LAST = TID_W'(RING - 1);

  logic [TID_W-1:0] ptr_q, ptr_d;
  logic             adv_en;

  assign adv_en = 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    if (adv_en) begin
      if (ptr_q == LAST) ptr_d = '0;
      else               ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign slot_o = ptr_q;

  // R2: step by one below the last slot
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));
  // R2: wrap from the last slot to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == LAST) |=> (ptr_q == '0));
endmodule

// File: rtl/fsched_upd_arb.sv
module fsched_upd_arb #(
  parameter int NUM_THR = 6,
  parameter int TID_W   = 3
) (
  input  logic               wb_vld,
  input  logic [TID_W-1:0]   wb_tid,
  input  logic               rply_vld,
  input  logic [TID_W-1:0]   rply_tid,
  output logic [NUM_THR-1:0] we_o
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic hit_wb, hit_rp;
    assign hit_wb  = wb_vld   && (wb_tid   == TID_W'(t));
    assign hit_rp  = rply_vld && (rply_tid == TID_W'(t));
    assign we_o[t] = hit_wb && !hit_rp;
  end
endmodule

// File: rtl/fsched_pc_bank.sv
module fsched_pc_bank #(
  parameter int          NUM_THR = 6,
  parameter int          PC_W    = 32,
  parameter logic [31:0] BOOT_PC = 32'h0000_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THR-1:0]            we_i,
  input  logic [PC_W-1:0]               wdata_i,
  output logic [NUM_THR-1:0][PC_W-1:0]  pc_o
);
  localparam logic [PC_W-1:0] BOOT = PC_W'(BOOT_PC);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_pc
    logic [PC_W-1:0] pc_q, pc_d;

    always_comb begin
      pc_d = pc_q;
      if (we_i[t]) pc_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= BOOT;
      else        pc_q <= pc_d;
    end

    assign pc_o[t] = pc_q;
  end
endmodule

// File: rtl/fsched_slot_mux.sv
module fsched_slot_mux #(
  parameter int NUM_THR = 6,
  parameter int TID_W   = 3,
  parameter int PC_W    = 32
) (
  input  logic [TID_W-1:0]              slot_i,
  input  logic [NUM_THR-1:0]            thr_en_i,
  input  logic [NUM_THR-1:0][PC_W-1:0]  pc_i,
  output logic                          vld_o,
  output logic [PC_W-1:0]               pc_o
);
  import fsched_pkg::*;

  slot_kind_e kind;
  logic       en_sel;

  always_comb begin
    pc_o   = '0;
    en_sel = 1'b0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (slot_i == TID_W'(t)) begin
        pc_o   = pc_i[t];
        en_sel = thr_en_i[t];
      end
    end
    if (int'(slot_i) >= NUM_THR) kind = SLOT_PAD;
    else if (!en_sel)            kind = SLOT_OFF;
    else                         kind = SLOT_ISSUE;
  end

  assign vld_o = (kind == SLOT_ISSUE);
endmodule

// File: rtl/thread_fetch_sched.sv
module thread_fetch_sched #(
  parameter int          NUM_THR = 6,
  parameter int          NUM_STG = 5,
  parameter int          PC_W    = 32,
  parameter logic [31:0] BOOT_PC = 32'h0000_0000,
  localparam int         RING    = fsched_pkg::ring_len(NUM_THR, NUM_STG),
  localparam int         TID_W   = (RING > 1) ? $clog2(RING) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_THR-1:0] thr_en,
  input  logic               rply_vld,
  input  logic [TID_W-1:0]   rply_tid,
  input  logic               wb_vld,
  input  logic [TID_W-1:0]   wb_tid,
  input  logic [PC_W-1:0]    wb_pc,
  output logic               fet_vld,
  output logic [TID_W-1:0]   fet_tid,
  output logic [PC_W-1:0]    fet_pc
);
  logic                         rst_i_n;
  logic [NUM_THR-1:0]           pc_we;
  logic [NUM_THR-1:0][PC_W-1:0] pc_all;

  fsched_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_i_n)
  );

  fsched_slot_ctr #(.RING(RING), .TID_W(TID_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .slot_o (fet_tid)
  );

  fsched_upd_arb #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_arb (
    .wb_vld   (wb_vld),
    .wb_tid   (wb_tid),
    .rply_vld (rply_vld),
    .rply_tid (rply_tid),
    .we_o     (pc_we)
  );

  fsched_pc_bank #(.NUM_THR(NUM_THR), .PC_W(PC_W), .BOOT_PC(BOOT_PC)) u_pcs (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .we_i    (pc_we),
    .wdata_i (wb_pc),
    .pc_o    (pc_all)
  );

  fsched_slot_mux #(.NUM_THR(NUM_THR), .TID_W(TID_W), .PC_W(PC_W)) u_mux (
    .slot_i   (fet_tid),
    .thr_en_i (thr_en),
    .pc_i     (pc_all),
    .vld_o    (fet_vld),
    .pc_o     (fet_pc)
  );

  // R1: slot held at zero while the synchronized reset is active
  a_r1_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_i_n) |-> (fet_tid == '0));

  // R4: a valid slot belongs to an enabled, existing thread
  a_r4_vld_needs_en: assert property (@(posedge clk) disable iff (!rst_i_n)
    fet_vld |-> ((int'(fet_tid) < NUM_THR) && thr_en[fet_tid]));

  if (RING > NUM_THR) begin : g_pad_chk
    // R6: padding slots are empty bubbles
    a_r6_pad_bubble: assert property (@(posedge clk) disable iff (!rst_i_n)
      (int'(fet_tid) >= NUM_THR) |-> (!fet_vld && (fet_pc == '0)));
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_pc_chk
    // R7: writeback without a colliding replay loads the PC
    a_r7_wb_load: assert property (@(posedge clk) disable iff (!rst_i_n)
      (wb_vld && (wb_tid == TID_W'(t)) && !(rply_vld && (rply_tid == TID_W'(t))))
      |=> (pc_all[t] == $past(wb_pc)));
    // R8: a replay for this thread keeps its PC
    a_r8_replay_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
      (rply_vld && (rply_tid == TID_W'(t))) |=> $stable(pc_all[t]));
  end
endmodule

// File: tb/sim_thread_fetch_sched.sv
module sim_thread_fetch_sched;
  localparam int N0 = 6, R0 = 6;
  localparam int N1 = 3, R1L = 5;
  localparam int STG = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  en0 = '0;
  logic [2:0]  en1 = '0;
  logic        rv = 1'b0, wv = 1'b0;
  logic [2:0]  rt = '0, wt = '0;
  logic [31:0] wp = '0;

  logic        v0, v1;
  logic [2:0]  t0, t1;
  logic [31:0] p0, p1;

  int errors = 0, checks = 0;
  int m_slot0 = 0, m_slot1 = 0;
  logic [31:0] m_pc0 [N0];
  logic [31:0] m_pc1 [N1];
  int h0 [STG-1];
  int h1 [STG-1];
  int hn = 0;
  logic [15:0] lf = 16'hACE1;
  bit done = 0;

  always #4 clk = ~clk;

  thread_fetch_sched u0 (
    .clk(clk), .rst_n(rst_n), .thr_en(en0), .rply_vld(rv), .rply_tid(rt),
    .wb_vld(wv), .wb_tid(wt), .wb_pc(wp),
    .fet_vld(v0), .fet_tid(t0), .fet_pc(p0));

  thread_fetch_sched #(.NUM_THR(N1), .NUM_STG(STG)) u1 (
    .clk(clk), .rst_n(rst_n), .thr_en(en1), .rply_vld(rv), .rply_tid(rt),
    .wb_vld(wv), .wb_tid(wt), .wb_pc(wp),
    .fet_vld(v1), .fet_tid(t1), .fet_pc(p1));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Check outputs after driving this cycle's inputs, then advance the model.
  task automatic cycle(input logic [5:0] e0, input logic rv_i, input logic [2:0] rt_i,
                       input logic wv_i, input logic [2:0] wt_i, input logic [31:0] wp_i,
                       input bit adv, input bit hist);
    logic ev0, ev1;
    logic [31:0] ep0, ep1;
    @(negedge clk);
    en0 = e0; en1 = e0[2:0];
    rv = rv_i; rt = rt_i; wv = wv_i; wt = wt_i; wp = wp_i;
    #1;
    ev0 = en0[m_slot0];
    ep0 = m_pc0[m_slot0];
    if (m_slot1 < N1) begin ev1 = en1[m_slot1]; ep1 = m_pc1[m_slot1]; end
    else begin ev1 = 1'b0; ep1 = '0; end
    chk(t0 == 3'(m_slot0), "R1 R2 R5 tid u0", 32'(t0), 32'(m_slot0));
    chk(t1 == 3'(m_slot1), "R1 R2 R5 tid u1", 32'(t1), 32'(m_slot1));
    chk(v0 == ev0, "R4 vld u0", 32'(v0), 32'(ev0));
    chk(v1 == ev1, "R4 R6 vld u1", 32'(v1), 32'(ev1));
    chk(p0 == ep0, "R1 R7 R8 R9 R10 R11 pc u0", p0, ep0);
    chk(p1 == ep1, "R1 R6 R7 R8 R9 R10 R11 pc u1", p1, ep1);
    if (hist) begin
      for (int k = 0; k < STG - 1; k++) begin
        if (k < hn) begin
          chk(int'(t0) != h0[k], "R3 spacing u0", 32'(t0), 32'(h0[k]));
          chk(int'(t1) != h1[k], "R3 spacing u1", 32'(t1), 32'(h1[k]));
        end
      end
      for (int k = STG - 2; k > 0; k--) begin h0[k] = h0[k-1]; h1[k] = h1[k-1]; end
      h0[0] = int'(t0); h1[0] = int'(t1);
      if (hn < STG - 1) hn++;
    end
    if (adv) begin
      if (wv_i && (int'(wt_i) < N0) && !(rv_i && rt_i == wt_i)) m_pc0[wt_i] = wp_i;
      if (wv_i && (int'(wt_i) < N1) && !(rv_i && rt_i == wt_i)) m_pc1[wt_i[1:0]] = wp_i;
      m_slot0 = (m_slot0 + 1) % R0;
      m_slot1 = (m_slot1 + 1) % R1L;
    end
  endtask

  initial begin
    for (int i = 0; i < N0; i++) m_pc0[i] = '0;
    for (int i = 0; i < N1; i++) m_pc1[i] = '0;
    // R1: reset state, with writebacks applied that must not land
    for (int i = 0; i < 3; i++) cycle(6'h3F, 1'b0, 3'd0, 1'b1, 3'(i), 32'hDEAD_0000, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // One cycle still inside the synchronizer window
    cycle(6'h3F, 1'b0, 3'd0, 1'b0, 3'd0, 32'h0, 1'b0, 1'b0);
    // Directed R9: replay for thread 2 next to a writeback to thread 1
    cycle(6'h3F, 1'b1, 3'd2, 1'b1, 3'd1, 32'h0000_ABC0, 1'b1, 1'b1);
    // Directed R8: colliding replay on thread 0
    cycle(6'h3F, 1'b1, 3'd0, 1'b1, 3'd0, 32'h1111_0000, 1'b1, 1'b1);
    // Directed R10: out-of-range thread id
    cycle(6'h3F, 1'b0, 3'd0, 1'b1, 3'd7, 32'h7777_0000, 1'b1, 1'b1);
    // Sweep every enable mask with pseudo-random update traffic
    for (int m = 0; m < 64; m++) begin
      for (int c = 0; c < 2 * R0; c++) begin
        logic [2:0] wt_n, rt_n;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        wt_n = lf[8:6];
        rt_n = lf[9] ? wt_n : lf[3:1];
        cycle(6'(m), lf[0], rt_n, lf[4] | lf[5], wt_n,
              {lf, lf ^ 16'(m * 37 + c)}, 1'b1, 1'b1);
      end
    end
    // R11: quiet period, PCs must hold across full rotations
    for (int c = 0; c < 3 * R0; c++) cycle(6'h15, 1'b0, 3'd0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule